// File: doc/BRIEF.md
# FIFO-Threshold DMA Request Generator

This block raises the two DMA request lines of one serial-peripheral channel from the fill levels of that channel's receive and transmit FIFOs. It does not hold the FIFOs, shift serial data or talk to the bus. It watches the byte counts reported by the FIFOs, compares them with two programmable thresholds, and drives one read-request line and one write-request line toward a DMA engine.

The write request follows a plain level compare: it is high while the channel is on, its own enable bit is set, and the transmit FIFO holds fewer bytes than the almost-empty threshold. The read request behaves differently. It rises once the receive FIFO reaches the almost-full threshold. The first completed receive-register read takes it down again. It then stays down until the reads that make up the whole threshold have been performed. An access counter inside the block tracks this. The counter is loaded with the threshold when the request rises and is decremented by the word size in bytes on every completed read.

Top module: `dma_req_gen`

## Requirements
- R1: One clock after an edge where the channel is enabled, the read enable bit is set, the access counter is zero and `rx_level >= rd_thresh`, `rd_req` is 1.
- R2: While `rd_enable` is 0, `rd_req` is 0 from the next clock on, including when it was high before.
- R3: A `rd_strobe` pulse sampled while `rd_req` is high makes `rd_req` 0 on the next clock, even if the receive FIFO is still above the threshold.
- R4: After a read request rises, it cannot rise again until completed reads totalling `rd_thresh` bytes have been counted, each read counting BYTES_PER_WORD bytes. After the last such read, `rd_req` is still 0 one clock later and becomes 1 on the second clock if the FIFO is still at or above the threshold.
- R5: One clock after any edge, `wr_req` equals (channel enabled AND `wr_enable` AND `tx_level < wr_thresh`).
- R6: The read and write enable bits are independent. Clearing `wr_enable` does not change `rd_req`, and clearing `rd_enable` does not change `wr_req`.
- R7: Driving `chan_en` to 0 clears both request lines on the next clock and discards any outstanding read count. After re-enabling, a read request can rise at once, with no reads performed in between.
- R8: While reset is held and after its release, both request lines are 0 and the access counter is zero (armed).
- R9: A `rd_strobe` pulse while the block is armed and no read request is up has no effect: a later threshold crossing still raises `rd_req` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| rd_enable | input | 1 | Read-request enable (1 lets the read request through) |
| wr_enable | input | 1 | Write-request enable (1 lets the write request through) |
| rd_thresh | input | LVL_W | Almost-full threshold in bytes (1..FIFO_DEPTH) |
| wr_thresh | input | LVL_W | Almost-empty threshold in bytes (1..FIFO_DEPTH) |
| rx_level | input | LVL_W | Bytes held in the receive FIFO |
| tx_level | input | LVL_W | Bytes held in the transmit FIFO |
| rd_strobe | input | 1 | One-clock pulse per completed receive-register read |
| rd_req | output | 1 | DMA read request, registered |
| wr_req | output | 1 | DMA write request, registered |

## Verification
The embedded assertions check these every cycle: the enable bits and the channel enable force the lines low on the next clock, a strobe during an active read request drops it, a read request rises only from an armed counter, and the counter is loaded with the threshold as the request rises. Only the bench scenarios show the full read-count window. That covers the exact clock on which the request re-arms after the last read for every threshold, the discarding of a partial count when the channel is turned off, and the fact that strobes outside a request are ignored. The write compare is swept over every level, threshold and enable combination of a small FIFO.

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
   // bits needed to hold a byte count from 0 to depth inclusive
   function automatic int lvl_bits(input int depth);
      return $clog2(depth + 1);
   endfunction
endpackage

// File: rtl/dmareq_acc_cnt.sv
module dmareq_acc_cnt #(
   parameter int LVL_W          = 5,
   parameter int BYTES_PER_WORD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [LVL_W-1:0] load_val,
   input  logic             dec,
   output logic [LVL_W-1:0] cnt,
   output logic             cnt_zero
);
   localparam int STEP_W = $clog2(BYTES_PER_WORD + 1);
   localparam logic [LVL_W-1:0] STEP = LVL_W'(BYTES_PER_WORD);

   logic [LVL_W-1:0] cnt_dec;

   generate
      if (BYTES_PER_WORD == 1) begin : g_unit
         assign cnt_dec = cnt - 1'b1;
      end else begin : g_sat
         // a word may carry more bytes than remain: clamp at zero
         assign cnt_dec = (cnt <= STEP) ? '0 : cnt - STEP;
      end
      if (STEP_W > LVL_W) begin : g_bad_step
         $error("dmareq_acc_cnt: word size exceeds counter range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (clr)   cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (dec)   cnt <= cnt_dec;
   end

   assign cnt_zero = (cnt == '0);

   AST_CNT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0); // R7
endmodule

// File: rtl/dmareq_rd_ctrl.sv
module dmareq_rd_ctrl #(
   parameter int LVL_W          = 5,
   parameter int BYTES_PER_WORD = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             rd_enable,
   input  logic [LVL_W-1:0] rd_thresh,
   input  logic [LVL_W-1:0] rx_level,
   input  logic             rd_strobe,
   output logic             rd_req
);
   logic [LVL_W-1:0] acc_cnt;
   logic             acc_zero;
   logic             fire;
   logic             req_nxt;
   logic             acc_dec;

   // raise only from the armed state, with the FIFO at threshold
   assign fire = chan_en && rd_enable && acc_zero && !rd_req &&
                 (rx_level >= rd_thresh);

   always_comb begin
      req_nxt = rd_req;
      if (!chan_en || !rd_enable)      req_nxt = 1'b0;
      else if (rd_req && rd_strobe)    req_nxt = 1'b0;
      else if (fire)                   req_nxt = 1'b1;
   end

   assign acc_dec = rd_strobe && !acc_zero;

   dmareq_acc_cnt #(
      .LVL_W         (LVL_W),
      .BYTES_PER_WORD(BYTES_PER_WORD)
   ) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (!chan_en),
      .load    (fire),
      .load_val(rd_thresh),
      .dec     (acc_dec),
      .cnt     (acc_cnt),
      .cnt_zero(acc_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_req <= 1'b0;
      else        rd_req <= req_nxt;
   end

   AST_RD_RISE_COND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_req) |-> $past(chan_en && rd_enable && rx_level >= rd_thresh)); // R1
   AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_enable |=> !rd_req); // R2
   AST_RD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && rd_strobe) |=> !rd_req); // R3
   AST_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_req) |-> $past(acc_zero)); // R4
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_req) |-> acc_cnt == $past(rd_thresh)); // R4
   AST_RD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !rd_req); // R7
endmodule

// File: rtl/dmareq_wr_ctrl.sv
module dmareq_wr_ctrl #(
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             wr_enable,
   input  logic [LVL_W-1:0] wr_thresh,
   input  logic [LVL_W-1:0] tx_level,
   output logic             wr_req
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_req <= 1'b0;
      else        wr_req <= chan_en && wr_enable && (tx_level < wr_thresh);
   end

   AST_WR_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && wr_enable && tx_level < wr_thresh) |=> wr_req); // R5
   AST_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_enable |=> !wr_req); // R6
   AST_WR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> !wr_req); // R7
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen #(
   parameter int FIFO_DEPTH     = 16,
   parameter int BYTES_PER_WORD = 1,
   localparam int LVL_W         = dmareq_pkg::lvl_bits(FIFO_DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             rd_enable,
   input  logic             wr_enable,
   input  logic [LVL_W-1:0] rd_thresh,
   input  logic [LVL_W-1:0] wr_thresh,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             rd_strobe,
   output logic             rd_req,
   output logic             wr_req
);
   generate
      if (FIFO_DEPTH < 2) begin : g_bad_depth
         $error("dma_req_gen: FIFO_DEPTH must be at least 2");
      end
      if (BYTES_PER_WORD != 1 && BYTES_PER_WORD != 2 && BYTES_PER_WORD != 4)
      begin : g_bad_word
         $error("dma_req_gen: BYTES_PER_WORD must be 1, 2 or 4");
      end
   endgenerate

   dmareq_rd_ctrl #(
      .LVL_W         (LVL_W),
      .BYTES_PER_WORD(BYTES_PER_WORD)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_en  (chan_en),
      .rd_enable(rd_enable),
      .rd_thresh(rd_thresh),
      .rx_level (rx_level),
      .rd_strobe(rd_strobe),
      .rd_req   (rd_req)
   );

   dmareq_wr_ctrl #(
      .LVL_W(LVL_W)
   ) u_wr (
      .clk      (clk),
      .rst_n    (rst_n),
      .chan_en  (chan_en),
      .wr_enable(wr_enable),
      .wr_thresh(wr_thresh),
      .tx_level (tx_level),
      .wr_req   (wr_req)
   );

   AST_RESET_LOW: assert property (@(posedge clk)
      !rst_n |-> (!rd_req && !wr_req)); // R8
endmodule

// File: tb/sim_dma_req_gen.sv
`timescale 1ns/100ps
module sim_dma_req_gen;
   localparam int DEPTH = 8;
   localparam int LW    = dmareq_pkg::lvl_bits(DEPTH);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          chan_en = 1'b0, rd_enable = 1'b0, wr_enable = 1'b0;
   logic [LW-1:0] rd_thresh = '0, wr_thresh = '0, rx_level = '0, tx_level = '0;
   logic          rd_strobe = 1'b0;
   logic          rd_req, wr_req;

   int errors = 0;
   int checks = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   dma_req_gen #(.FIFO_DEPTH(DEPTH), .BYTES_PER_WORD(1)) u0 (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .rd_enable(rd_enable),
      .wr_enable(wr_enable), .rd_thresh(rd_thresh), .wr_thresh(wr_thresh),
      .rx_level(rx_level), .tx_level(tx_level), .rd_strobe(rd_strobe),
      .rd_req(rd_req), .wr_req(wr_req));

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
      end
   endtask

   // advance one edge, then sample 1 ns after it
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic strobe();
      rd_strobe = 1'b1;
      tick();
      rd_strobe = 1'b0;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles >= 200000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R8: reset state
      tick();
      check("R8 rd_req in reset", rd_req, 1'b0);
      check("R8 wr_req in reset", wr_req, 1'b0);
      rst_n = 1'b1;
      tick();
      check("R8 rd_req after reset", rd_req, 1'b0);
      check("R8 wr_req after reset", wr_req, 1'b0);

      // R5: exhaustive write compare
      for (int en = 0; en < 2; en++)
         for (int wm = 0; wm < 2; wm++)
            for (int th = 1; th <= DEPTH; th++)
               for (int lv = 0; lv <= DEPTH; lv++) begin
                  chan_en = en[0]; wr_enable = wm[0];
                  wr_thresh = LW'(th); tx_level = LW'(lv);
                  tick();
                  check("R5 write compare", wr_req,
                        logic'(en == 1 && wm == 1 && lv < th));
               end

      // R1 R3 R4: read window for every threshold
      wr_enable = 1'b0;
      for (int th = 1; th <= DEPTH; th++) begin
         chan_en = 1'b0; rd_enable = 1'b1; rd_thresh = LW'(th);
         rx_level = LW'(th - 1);
         tick();
         chan_en = 1'b1;
         tick(); tick();
         check("R1 below threshold stays low", rd_req, 1'b0);
         rx_level = LW'(th);
         tick();
         check("R1 rise at threshold", rd_req, 1'b1);
         rx_level = LW'(DEPTH);
         strobe();
         check("R3 drop on first read", rd_req, 1'b0);
         for (int k = 1; k < th; k++) begin
            check("R4 held low mid-window", rd_req, 1'b0);
            strobe();
         end
         check("R4 low one clock after last read", rd_req, 1'b0);
         tick();
         check("R4 rearm after full count", rd_req, 1'b1);
      end

      // R2: read enable bit
      chan_en = 1'b0; tick(); chan_en = 1'b1;
      rd_enable = 1'b0; rd_thresh = 4; rx_level = 6;
      tick(); tick();
      check("R2 masked stays low", rd_req, 1'b0);
      rd_enable = 1'b1;
      tick();
      check("R2 unmasked rises", rd_req, 1'b1);

      // R6: clearing write enable leaves read request alone
      wr_enable = 1'b1; wr_thresh = 4; tx_level = 0;
      tick();
      check("R6 wr high", wr_req, 1'b1);
      wr_enable = 1'b0;
      tick();
      check("R6 rd unchanged by wr enable", rd_req, 1'b1);
      check("R6 wr low", wr_req, 1'b0);
      wr_enable = 1'b1;
      tick();
      rd_enable = 1'b0;
      tick();
      check("R2 mask drops active request", rd_req, 1'b0);
      check("R6 wr unchanged by rd enable", wr_req, 1'b1);
      rd_enable = 1'b1;

      // R7: disable discards a partial count
      chan_en = 1'b0; tick(); chan_en = 1'b1;
      tick();
      check("R7 rise after enable", rd_req, 1'b1);
      strobe();
      check("R7 dropped, count pending", rd_req, 1'b0);
      tick();
      check("R7 still blocked", rd_req, 1'b0);
      chan_en = 1'b0;
      tick();
      check("R7 rd cleared", rd_req, 1'b0);
      check("R7 wr cleared", wr_req, 1'b0);
      chan_en = 1'b1;
      tick();
      check("R7 rearm without reads", rd_req, 1'b1);

      // R9: strobe while armed and idle is ignored
      chan_en = 1'b0; tick(); chan_en = 1'b1;
      rx_level = 2;
      tick();
      strobe(); strobe();
      check("R9 idle strobe no request", rd_req, 1'b0);
      rx_level = 4;
      tick();
      check("R9 idle strobe ignored", rd_req, 1'b1);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule